// File: doc/BRIEF.md
# Scaled Fast Forward 8-Point DCT Datapath

This block computes a one-dimensional forward discrete cosine transform of eight signed 16-bit samples. It follows the scaled fast flow. An input butterfly splits the samples into four sums and four differences. An even section turns the sums into coefficients 0, 2, 4 and 6. An odd section turns the differences into coefficients 1, 3, 5 and 7. Five multiplications by fixed-point constants are needed in all. Every one goes through a saturating "multiply-high then add" step, so the results match a vector-integer software implementation bit for bit.

The coefficients stay scaled. Per-coefficient descaling is expected to happen in a later quantizer. A two-dimensional transform is built by running rows and then columns through this datapath, with a transposition outside the block.

Each transfer is an eight-lane vector qualified by a valid strobe. With the default `LATENCY` of 1, the result is registered and appears one clock after the vector is accepted. With `LATENCY` of 0, the datapath is purely combinational.

Top module: `fdct8_fast`

## Requirements
- R1: The butterfly forms sum k as lane k plus lane 7−k, for k = 0..3. It forms difference k as lane k minus lane 7−k.
- R2: Let A = sum0 + sum3 and B = sum1 + sum2. Coefficient 0 is A + B and coefficient 4 is A − B.
- R3: Let D = sum0 − sum3 and E = sum1 − sum2. Let m0 = mulhi(prescale(E + D), 181·32, 0). Coefficient 2 is D + m0 and coefficient 6 is D − m0.
- R4: mulhi(a, k, c) takes the signed 32-bit product a·k, shifts it arithmetically right by 15, and adds c. The total is clamped to −32768..32767. The constants are 98, 139, 181 and 334, each multiplied by 32.
- R5: prescale(v) shifts v left by 2 in 16 bits. The top two bits are discarded, and the result is not widened.
- R6: Let P = prescale(diff3 + diff2) and Q = prescale(diff1 + diff0). Then r = mulhi(P − Q, 98·32, 0), g = mulhi(P, 139·32, r) and h = mulhi(Q, 334·32, r). These two additions saturate because they happen inside mulhi.
- R7: Let n = mulhi(prescale(diff2 + diff1), 181·32, 0), u = diff0 + n and w = diff0 − n. Coefficients 1 and 7 are u + h and u − h. Coefficients 5 and 3 are w + g and w − g.
- R8: Every plain addition and subtraction wraps modulo 2^16, with no saturation.
- R9: With LATENCY=1, out_valid equals in_valid delayed by one clock. While rst_n is low, out_valid and out_data are zero.
- R10: With LATENCY=1, out_data loads only on a clock where in_valid is high. Otherwise it keeps its value.
- R11: Lane k of in_data sits at bits [16k+15:16k], and coefficient k of out_data sits at the same bits. Both are two's complement.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_valid | input | 1 | Input vector is valid |
| in_data | input | 128 | Eight signed 16-bit samples, lane k at bits [16k+15:16k] |
| out_valid | output | 1 | Output vector is valid |
| out_data | output | 128 | Eight scaled signed 16-bit coefficients, lane k at bits [16k+15:16k] |

## Verification
The assertions check, on every clock, modular identities that tie the butterfly to the outputs:
- coefficients 0 and 4 add up to twice sum0 + sum3;
- coefficients 2 and 6 add up to twice sum0 − sum3;
- the four odd coefficients add up to four times difference 0;
- the butterfly sum and difference of lane 0 add up to twice that lane.

They also check the one-cycle valid delay, the register load and the hold. The multiply constants, the rounding of the shift by 15, the discarded prescale bits and the exact odd-part combinations fall outside those identities. Only the bench can show them, by comparing every lane against an integer model. It does so over impulse sweeps on each lane, extreme and wrapping patterns, and random vectors.

// File: rtl/fdct_pkg.sv
package fdct_pkg;
  localparam int W      = 16;
  localparam int LANES  = 8;
  localparam int HALF   = LANES / 2;
  localparam int PRE    = 2;
  localparam int FRAC   = 8;
  localparam int KSHIFT = W - PRE - FRAC - 1;
  localparam int HI_LSB = W - 1;

  typedef logic signed [W-1:0] smp_t;
  typedef logic [HALF-1:0][W-1:0] half_t;
  typedef logic [LANES-1:0][W-1:0] vec_t;

  localparam smp_t K382  = smp_t'(98  << KSHIFT);
  localparam smp_t K541  = smp_t'(139 << KSHIFT);
  localparam smp_t K707  = smp_t'(181 << KSHIFT);
  localparam smp_t K1306 = smp_t'(334 << KSHIFT);

  localparam logic signed [W+1:0] SAT_HI = 18'sd32767;
  localparam logic signed [W+1:0] SAT_LO = -18'sd32768;

  function automatic smp_t wadd(input smp_t a, input smp_t b);
    return smp_t'(a + b);
  endfunction

  function automatic smp_t wsub(input smp_t a, input smp_t b);
    return smp_t'(a - b);
  endfunction

  function automatic smp_t prescale(input smp_t a);
    return smp_t'(a <<< PRE);
  endfunction

  function automatic smp_t mulhi_sat(input smp_t a, input smp_t k, input smp_t addend);
    logic signed [2*W-1:0] prod;
    logic signed [W+1:0]   hi;
    logic signed [W+1:0]   sum;
    prod = a * k;
    hi   = {prod[2*W-1], prod[2*W-1:HI_LSB]};
    sum  = hi + {{2{addend[W-1]}}, addend};
    if (sum > SAT_HI)      return smp_t'(SAT_HI);
    else if (sum < SAT_LO) return smp_t'(SAT_LO);
    else                   return smp_t'(sum);
  endfunction
endpackage

// File: rtl/fdct_butterfly.sv
module fdct_butterfly
  import fdct_pkg::*;
(
  input  vec_t  x,
  output half_t sums,
  output half_t difs
);
  for (genvar k = 0; k < HALF; k++) begin : g_bf
    assign sums[k] = wadd(smp_t'(x[k]), smp_t'(x[LANES-1-k]));
    assign difs[k] = wsub(smp_t'(x[k]), smp_t'(x[LANES-1-k]));
  end
endmodule

// File: rtl/fdct_even.sv
module fdct_even
  import fdct_pkg::*;
(
  input  half_t sums,
  output smp_t  c0,
  output smp_t  c2,
  output smp_t  c4,
  output smp_t  c6
);
  smp_t ea, eb, ed, ee, m0;

  always_comb begin
    ea = wadd(smp_t'(sums[0]), smp_t'(sums[3]));
    ed = wsub(smp_t'(sums[0]), smp_t'(sums[3]));
    eb = wadd(smp_t'(sums[1]), smp_t'(sums[2]));
    ee = wsub(smp_t'(sums[1]), smp_t'(sums[2]));
    m0 = mulhi_sat(prescale(wadd(ee, ed)), K707, '0);
    c0 = wadd(ea, eb);
    c4 = wsub(ea, eb);
    c2 = wadd(ed, m0);
    c6 = wsub(ed, m0);
  end
endmodule

// File: rtl/fdct_odd.sv
module fdct_odd
  import fdct_pkg::*;
(
  input  half_t difs,
  output smp_t  c1,
  output smp_t  c3,
  output smp_t  c5,
  output smp_t  c7
);
  smp_t p, q, mid, r, g, h, n, u, w;

  always_comb begin
    p   = prescale(wadd(smp_t'(difs[3]), smp_t'(difs[2])));
    mid = prescale(wadd(smp_t'(difs[2]), smp_t'(difs[1])));
    q   = prescale(wadd(smp_t'(difs[1]), smp_t'(difs[0])));
    r   = mulhi_sat(wsub(p, q), K382, '0);
    g   = mulhi_sat(p, K541, r);
    h   = mulhi_sat(q, K1306, r);
    n   = mulhi_sat(mid, K707, '0);
    u   = wadd(smp_t'(difs[0]), n);
    w   = wsub(smp_t'(difs[0]), n);
    c1  = wadd(u, h);
    c7  = wsub(u, h);
    c5  = wadd(w, g);
    c3  = wsub(w, g);
  end
endmodule

// File: rtl/fdct8_fast.sv
module fdct8_fast
  import fdct_pkg::*;
#(
  parameter int LATENCY = 1
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 in_valid,
  input  logic [LANES*W-1:0]   in_data,
  output logic                 out_valid,
  output logic [LANES*W-1:0]   out_data
);
  vec_t  x_vec;
  half_t bf_sum;
  half_t bf_dif;
  vec_t  coef;
  smp_t  c0, c1, c2, c3, c4, c5, c6, c7;

  assign x_vec = vec_t'(in_data);

  fdct_butterfly i_bf (
    .x    (x_vec),
    .sums (bf_sum),
    .difs (bf_dif)
  );

  fdct_even i_even (
    .sums (bf_sum),
    .c0   (c0),
    .c2   (c2),
    .c4   (c4),
    .c6   (c6)
  );

  fdct_odd i_odd (
    .difs (bf_dif),
    .c1   (c1),
    .c3   (c3),
    .c5   (c5),
    .c7   (c7)
  );

  assign coef = {c7, c6, c5, c4, c3, c2, c1, c0};

  if (LATENCY == 0) begin : g_comb
    assign out_valid = in_valid;
    assign out_data  = coef;
  end else begin : g_reg
    logic               v_q;
    logic [LANES*W-1:0] d_q;
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        v_q <= 1'b0;
        d_q <= '0;
      end else begin
        v_q <= in_valid;
        if (in_valid) d_q <= coef;
      end
    end
    assign out_valid = v_q;
    assign out_data  = d_q;
  end
endmodule

// File: rtl/fdct8_chk.sv
module fdct8_chk #(
  parameter int LATENCY = 1
) (
  input logic            clk,
  input logic            rst_n,
  input logic            in_valid,
  input logic [127:0]    in_data,
  input logic            out_valid,
  input logic [127:0]    out_data,
  input logic [3:0][15:0] bf_sum,
  input logic [3:0][15:0] bf_dif,
  input logic [7:0][15:0] coef
);
  AST_BF_LANE0: assert property (@(posedge clk) disable iff (!rst_n)
    16'(bf_sum[0] + bf_dif[0]) == 16'(in_data[15:0] << 1)); // R1

  AST_EVEN_DC: assert property (@(posedge clk) disable iff (!rst_n)
    16'(coef[0] + coef[4]) == 16'((bf_sum[0] + bf_sum[3]) << 1)); // R2

  AST_EVEN_MID: assert property (@(posedge clk) disable iff (!rst_n)
    16'(coef[2] + coef[6]) == 16'((bf_sum[0] - bf_sum[3]) << 1)); // R3

  AST_ODD_SUM: assert property (@(posedge clk) disable iff (!rst_n)
    16'(coef[1] + coef[7] + coef[3] + coef[5]) == 16'(bf_dif[0] << 2)); // R7

  if (LATENCY != 0) begin : g_seq
    AST_VALID_DELAY: assert property (@(posedge clk) disable iff (!rst_n)
      in_valid |=> out_valid); // R9
    AST_VALID_DROP: assert property (@(posedge clk) disable iff (!rst_n)
      !in_valid |=> !out_valid); // R9
    AST_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
      in_valid |=> out_data == $past(coef)); // R10
    AST_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
      !in_valid |=> $stable(out_data)); // R10
  end
endmodule

bind fdct8_fast fdct8_chk #(.LATENCY(LATENCY)) i_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .in_valid  (in_valid),
  .in_data   (in_data),
  .out_valid (out_valid),
  .out_data  (out_data),
  .bf_sum    (bf_sum),
  .bf_dif    (bf_dif),
  .coef      (coef)
);

// File: tb/test_fdct8_fast.sv
module test_fdct8_fast;
  logic         clk = 1'b0;
  logic         rst_n = 1'b0;
  logic         in_valid = 1'b0;
  logic [127:0] in_data = '0;
  logic         out_valid;
  logic [127:0] out_data;

  int n_tests = 0;
  int n_fail  = 0;
  bit done    = 1'b0;

  always #2 clk = ~clk;

  fdct8_fast i_fdct8_fast (
    .clk       (clk),
    .rst_n     (rst_n),
    .in_valid  (in_valid),
    .in_data   (in_data),
    .out_valid (out_valid),
    .out_data  (out_data)
  );

  // Reference model in plain integers
  function automatic int wr(input int v);
    int m;
    m = v & 32'hFFFF;
    return (m >= 32768) ? m - 65536 : m;
  endfunction

  function automatic int mh(input int a, input int k, input int c);
    int s;
    s = ((a * k) >>> 15) + c;
    if (s > 32767)  s = 32767;
    if (s < -32768) s = -32768;
    return s;
  endfunction

  function automatic int ps(input int v);
    return wr(v * 4);
  endfunction

  function automatic logic [127:0] model(input logic [127:0] vin);
    int x[8];
    int y[8];
    int s0, s1, s2, s3, d0, d1, d2, d3;
    int a, b, d, e, m0, p, q, mid, r, g, h, n, u, w;
    logic [127:0] res;
    for (int i = 0; i < 8; i++) x[i] = wr(int'(vin[16*i +: 16]));
    s0 = wr(x[0] + x[7]); d0 = wr(x[0] - x[7]);
    s1 = wr(x[1] + x[6]); d1 = wr(x[1] - x[6]);
    s2 = wr(x[2] + x[5]); d2 = wr(x[2] - x[5]);
    s3 = wr(x[3] + x[4]); d3 = wr(x[3] - x[4]);
    a = wr(s0 + s3); d = wr(s0 - s3);
    b = wr(s1 + s2); e = wr(s1 - s2);
    y[0] = wr(a + b); y[4] = wr(a - b);
    m0 = mh(ps(wr(e + d)), 181 * 32, 0);
    y[2] = wr(d + m0); y[6] = wr(d - m0);
    p   = ps(wr(d3 + d2));
    mid = ps(wr(d2 + d1));
    q   = ps(wr(d1 + d0));
    r = mh(wr(p - q), 98 * 32, 0);
    g = mh(p, 139 * 32, r);
    h = mh(q, 334 * 32, r);
    n = mh(mid, 181 * 32, 0);
    u = wr(d0 + n); w = wr(d0 - n);
    y[1] = wr(u + h); y[7] = wr(u - h);
    y[5] = wr(w + g); y[3] = wr(w - g);
    for (int i = 0; i < 8; i++) res[16*i +: 16] = 16'(y[i]);
    return res;
  endfunction

  function automatic string lane_req(input int k);
    if (k == 0 || k == 4) return "R2";
    if (k == 2 || k == 6) return "R3";
    return "R7";
  endfunction

  task automatic apply(input logic [127:0] v, input string tag);
    logic [127:0] exp;
    int bad;
    exp = model(v);
    @(negedge clk);
    in_data  = v;
    in_valid = 1'b1;
    @(negedge clk);
    in_valid = 1'b0;
    in_data  = ~v;
    n_tests++;
    bad = -1;
    for (int k = 7; k >= 0; k--)
      if (out_data[16*k +: 16] !== exp[16*k +: 16]) bad = k;
    if (bad >= 0) begin
      n_fail++;
      $display("FAIL %s/%s lane %0d: got %0d expected %0d", tag, lane_req(bad), bad,
               $signed(out_data[16*bad +: 16]), $signed(exp[16*bad +: 16]));
    end
    n_tests++;
    if (out_valid !== 1'b1) begin
      n_fail++;
      $display("FAIL R9 out_valid: got %b expected 1", out_valid);
    end
    @(negedge clk);
    n_tests++;
    if (out_valid !== 1'b0 || out_data !== exp) begin
      n_fail++;
      $display("FAIL R10 hold: valid %b data %h expected valid 0 data %h", out_valid, out_data, exp);
    end
  endtask

  function automatic logic [127:0] fill(input int v);
    logic [127:0] r;
    for (int i = 0; i < 8; i++) r[16*i +: 16] = 16'(v);
    return r;
  endfunction

  function automatic logic [127:0] rnd(input int span);
    logic [127:0] r;
    for (int i = 0; i < 8; i++) r[16*i +: 16] = 16'(int'($urandom_range(2 * span)) - span);
    return r;
  endfunction

  initial begin
    int vals[10] = '{1, -1, 127, -128, 1000, -1000, 16383, -16384, 32767, -32768};
    logic [127:0] v;
    repeat (3) @(negedge clk);
    n_tests++;
    if (out_valid !== 1'b0 || out_data !== '0) begin
      n_fail++;
      $display("FAIL R9 reset: valid %b data %h expected 0", out_valid, out_data);
    end
    rst_n = 1'b1;
    // R11 impulse on each lane
    for (int k = 0; k < 8; k++)
      for (int j = 0; j < 10; j++) begin
        v = '0;
        v[16*k +: 16] = 16'(vals[j]);
        apply(v, "R11");
      end
    // R8 wrapping extremes
    apply(fill(32767), "R8");
    apply(fill(-32768), "R8");
    apply({4{16'sh7fff, 16'sh8000}}, "R8");
    apply({2{32'h7fff7fff, 32'h80008000}}, "R8");
    // R1 symmetric and antisymmetric inputs
    for (int j = 0; j < 50; j++) begin
      v = rnd(32768);
      for (int k = 0; k < 4; k++) v[16*(7-k) +: 16] = v[16*k +: 16];
      apply(v, "R1");
      for (int k = 0; k < 4; k++) v[16*(7-k) +: 16] = 16'(-int'($signed(v[16*k +: 16])));
      apply(v, "R1");
    end
    // R5 prescale overflow range
    for (int j = 0; j < 400; j++) apply(rnd(12000) + fill(8000), "R5");
    // R6 small-range odd part
    for (int j = 0; j < 600; j++) apply(rnd(300), "R6");
    // R4 full range random
    for (int j = 0; j < 3000; j++) apply(rnd(32768), "R4");
    done = 1'b1;
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      n_tests++;
      n_fail++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  end
endmodule